// File: doc/BRIEF.md
# Bidirectional Byte-Parity Transceiver Stage

This block moves a 16-bit word, split into two bytes, between an A side and a B side. Every byte travels with a parity bit, so each side carries 18 bits. Each direction has its own storage stage with three ways of working. With its latch enable high the stage is transparent. With the enable low, a capture strobe loads the stage on the rising edge of the system clock. With the enable low and no strobe, the stage holds its stored word.

In the A-to-B direction a mode input chooses between two behaviours. In generate mode the outgoing B parity bits are computed from the data. In check mode the A parity bits are passed through and verified. The B-to-A direction always passes and verifies the parity that came with the B data. A single odd/even select sets the parity sense for both directions. Each direction reports one active-low error flag, low when either byte fails and released high otherwise. The flag is qualified by that direction's output enable, so it can be wire-ORed with other flags and masked while the bus changes. Tri-state pins are modelled as data outputs plus a per-side drive-enable signal.

Top module: `parity_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both storage stages to zero. After reset, with latch enables low, no strobe and output enables high, both sides present zero data and zero parity.
- R2: While a direction's latch enable is high, that direction's data output equals its data input in the same cycle.
- R3: With the latch enable low, a high capture strobe loads the input word (data and parity) at the rising clock edge. The output shows the new word from that edge onward.
- R4: With the latch enable low and the strobe low, the output holds its stored word whatever the input does.
- R5: With the A-to-B mode input high (generate), b_par_out[i] is computed from data bits [8i+7:8i] of the word presented on B so that the byte and its bit have the selected sense. In this mode ab_err_n stays high.
- R6: With the mode input low (check), b_par_out carries the stored A parity bits. ab_err_n goes low when byte 0, byte 1 or both fail the check.
- R7: The B-to-A direction ignores the mode input. It always passes the stored B parity to a_par_out and drives ba_err_n low when either byte fails.
- R8: odd_sel high means a byte is correct when the byte plus its parity bit hold an odd number of ones. odd_sel low means an even number. One select serves both directions.
- R9: While a direction's output enable is low, its data and parity outputs are zero, its drive-enable output is low and its error flag is high, even when the stored word has a parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | Parity sense, 1 = odd, 0 = even (both directions) |
| gen_mode | input | 1 | A-to-B: 1 = generate B parity, 0 = check A parity |
| a_data_in | input | 16 | Data arriving on the A side |
| a_par_in | input | 2 | Parity bits arriving on the A side, bit i for byte i |
| a_data_out | output | 16 | Data driven onto the A side |
| a_par_out | output | 2 | Parity driven onto the A side |
| a_drive | output | 1 | A-side drive enable |
| b_data_in | input | 16 | Data arriving on the B side |
| b_par_in | input | 2 | Parity bits arriving on the B side |
| b_data_out | output | 16 | Data driven onto the B side |
| b_par_out | output | 2 | Parity driven onto the B side |
| b_drive | output | 1 | B-side drive enable |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_cap | input | 1 | A-to-B capture strobe |
| ab_oe | input | 1 | A-to-B output enable |
| ba_le | input | 1 | B-to-A latch enable |
| ba_cap | input | 1 | B-to-A capture strobe |
| ba_oe | input | 1 | B-to-A output enable |
| ab_err_n | output | 1 | A-to-B parity error, active-low pull-down |
| ba_err_n | output | 1 | B-to-A parity error, active-low pull-down |

## Verification
A corrupted stored word reaches the far side's data and parity pins in the same cycle the stage is read. The error flag moves in that same cycle, so every fault in the storage stage shows up at the ports no later than the first sample after the capturing edge. A stage that loads without a strobe, or fails to load with one, shows up at the first held cycle after it. Faults in parity selection show up as a wrong parity bit or a wrong flag on the very sample where the bad byte is presented. The bench therefore compares every port on every cycle against a model: directed patterns for each mode and each error placement, followed by random traffic.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

    parameter int BYTE_W    = 8;
    parameter int NUM_BYTES = 2;
    localparam int DATA_W   = BYTE_W * NUM_BYTES;

    typedef struct packed {
        logic [NUM_BYTES-1:0] par;
        logic [DATA_W-1:0]    data;
    } xword_t;

    // Parity bit per byte that gives the byte plus bit the requested sense.
    function automatic logic [NUM_BYTES-1:0] make_parity(
        input logic [DATA_W-1:0] d,
        input logic              odd
    );
        logic [NUM_BYTES-1:0] p;
        for (int b = 0; b < NUM_BYTES; b++) begin
            p[b] = (^d[b*BYTE_W +: BYTE_W]) ^ odd;
        end
        return p;
    endfunction

    // One bit per byte, set when byte plus its parity bit has the wrong sense.
    function automatic logic [NUM_BYTES-1:0] byte_faults(
        input xword_t w,
        input logic   odd
    );
        logic [NUM_BYTES-1:0] e;
        for (int b = 0; b < NUM_BYTES; b++) begin
            e[b] = (^w.data[b*BYTE_W +: BYTE_W]) ^ w.par[b] ^ odd;
        end
        return e;
    endfunction

endpackage

// File: rtl/xcvr_stage.sv
module xcvr_stage
    import parity_xcvr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   le,
    input  logic   cap,
    input  xword_t din,
    output xword_t dout
);

    xword_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (cap) begin
            held_q <= din;
        end
    end

    always_comb begin
        dout = le ? din : held_q;
    end

    // R4: no strobe and opaque on both cycles -> word unchanged
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!le && !cap) ##1 !le |-> $stable(dout));

endmodule

// File: rtl/parity_path.sv
module parity_path
    import parity_xcvr_pkg::*;
#(
    parameter bit CAN_GEN = 1'b1
)(
    input  logic   gen,
    input  logic   odd,
    input  logic   oe,
    input  xword_t word,
    output xword_t bus,
    output logic   err_n,
    output logic   drive
);

    logic                 gen_eff;
    logic [NUM_BYTES-1:0] faults;
    logic [NUM_BYTES-1:0] par_sel;

    generate
        if (CAN_GEN) begin : g_gen
            assign gen_eff = gen;
        end else begin : g_chk
            logic unused_gen;
            assign unused_gen = gen;
            assign gen_eff    = 1'b0;
        end
    endgenerate

    always_comb begin
        faults   = byte_faults(word, odd);
        par_sel  = gen_eff ? make_parity(word.data, odd) : word.par;
        bus.data = oe ? word.data : '0;
        bus.par  = oe ? par_sel   : '0;
        err_n    = !(oe && !gen_eff && (|faults));
        drive    = oe;
    end

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import parity_xcvr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 odd_sel,
    input  logic                 gen_mode,
    input  logic [DATA_W-1:0]    a_data_in,
    input  logic [NUM_BYTES-1:0] a_par_in,
    output logic [DATA_W-1:0]    a_data_out,
    output logic [NUM_BYTES-1:0] a_par_out,
    output logic                 a_drive,
    input  logic [DATA_W-1:0]    b_data_in,
    input  logic [NUM_BYTES-1:0] b_par_in,
    output logic [DATA_W-1:0]    b_data_out,
    output logic [NUM_BYTES-1:0] b_par_out,
    output logic                 b_drive,
    input  logic                 ab_le,
    input  logic                 ab_cap,
    input  logic                 ab_oe,
    input  logic                 ba_le,
    input  logic                 ba_cap,
    input  logic                 ba_oe,
    output logic                 ab_err_n,
    output logic                 ba_err_n
);

    xword_t ab_in, ab_word, ab_bus;
    xword_t ba_in, ba_word, ba_bus;

    assign ab_in = '{par: a_par_in, data: a_data_in};
    assign ba_in = '{par: b_par_in, data: b_data_in};

    xcvr_stage u_ab_stage (
        .clk(clk), .rst(rst), .le(ab_le), .cap(ab_cap), .din(ab_in), .dout(ab_word)
    );
    xcvr_stage u_ba_stage (
        .clk(clk), .rst(rst), .le(ba_le), .cap(ba_cap), .din(ba_in), .dout(ba_word)
    );

    parity_path #(.CAN_GEN(1'b1)) u_ab_par (
        .gen(gen_mode), .odd(odd_sel), .oe(ab_oe), .word(ab_word),
        .bus(ab_bus), .err_n(ab_err_n), .drive(b_drive)
    );
    parity_path #(.CAN_GEN(1'b0)) u_ba_par (
        .gen(gen_mode), .odd(odd_sel), .oe(ba_oe), .word(ba_word),
        .bus(ba_bus), .err_n(ba_err_n), .drive(a_drive)
    );

    assign b_data_out = ab_bus.data;
    assign b_par_out  = ab_bus.par;
    assign a_data_out = ba_bus.data;
    assign a_par_out  = ba_bus.par;

    // R2: transparent pass-through
    p_pass_ab_r2: assert property (@(posedge clk) disable iff (rst)
        (ab_le && ab_oe) |-> b_data_out == a_data_in);
    p_pass_ba_r2: assert property (@(posedge clk) disable iff (rst)
        (ba_le && ba_oe) |-> a_data_out == b_data_in);

    // R3: strobed capture appears after the edge
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && ab_cap) ##1 (!ab_le && ab_oe) |-> b_data_out == $past(a_data_in));

    // R9: disabled side is quiet and its flag released
    p_off_ab_r9: assert property (@(posedge clk) disable iff (rst)
        !ab_oe |-> (ab_err_n && !b_drive && b_data_out == '0 && b_par_out == '0));
    p_off_ba_r9: assert property (@(posedge clk) disable iff (rst)
        !ba_oe |-> (ba_err_n && !a_drive && a_data_out == '0 && a_par_out == '0));

    generate
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte_chk
            // R5, R8: generated parity has the selected sense, flag quiet
            p_gen_r5: assert property (@(posedge clk) disable iff (rst)
                (ab_oe && gen_mode) |->
                    (ab_err_n &&
                     ($countones({b_data_out[i*BYTE_W +: BYTE_W], b_par_out[i]}) % 2
                         == int'(odd_sel))));
            // R6: released flag in check mode means byte is good
            p_ab_flag_r6: assert property (@(posedge clk) disable iff (rst)
                (ab_oe && !gen_mode && ab_err_n) |->
                    ($countones({b_data_out[i*BYTE_W +: BYTE_W], b_par_out[i]}) % 2
                         == int'(odd_sel)));
            // R7: released flag on B-to-A means byte is good
            p_ba_flag_r7: assert property (@(posedge clk) disable iff (rst)
                (ba_oe && ba_err_n) |->
                    ($countones({a_data_out[i*BYTE_W +: BYTE_W], a_par_out[i]}) % 2
                         == int'(odd_sel)));
        end
    endgenerate

endmodule

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
    import parity_xcvr_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst, odd_sel, gen_mode;
    logic [DATA_W-1:0]    a_data_in, b_data_in, a_data_out, b_data_out;
    logic [NUM_BYTES-1:0] a_par_in, b_par_in, a_par_out, b_par_out;
    logic                 a_drive, b_drive, ab_err_n, ba_err_n;
    logic                 ab_le, ab_cap, ab_oe, ba_le, ba_cap, ba_oe;

    parity_xcvr uut (
        .clk(clk), .rst(rst), .odd_sel(odd_sel), .gen_mode(gen_mode),
        .a_data_in(a_data_in), .a_par_in(a_par_in),
        .a_data_out(a_data_out), .a_par_out(a_par_out), .a_drive(a_drive),
        .b_data_in(b_data_in), .b_par_in(b_par_in),
        .b_data_out(b_data_out), .b_par_out(b_par_out), .b_drive(b_drive),
        .ab_le(ab_le), .ab_cap(ab_cap), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_cap(ba_cap), .ba_oe(ba_oe),
        .ab_err_n(ab_err_n), .ba_err_n(ba_err_n)
    );

    typedef struct {
        string                tag;
        logic [DATA_W-1:0]    bd, ad;
        logic [NUM_BYTES-1:0] bp, ap;
        logic                 bdrv, adrv, abe, bae;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    logic [DATA_W-1:0]    m_ab_d, m_ba_d;
    logic [NUM_BYTES-1:0] m_ab_p, m_ba_p;

    function automatic int ones_in_byte(input logic [DATA_W-1:0] d, input int b);
        int c = 0;
        for (int i = 0; i < BYTE_W; i++) c += int'(d[b*BYTE_W + i]);
        return c;
    endfunction

    function automatic logic [NUM_BYTES-1:0] ref_par(input logic [DATA_W-1:0] d, input logic odd);
        logic [NUM_BYTES-1:0] p;
        for (int b = 0; b < NUM_BYTES; b++) p[b] = ((ones_in_byte(d, b) % 2) != int'(odd));
        return p;
    endfunction

    function automatic logic ref_bad(input logic [DATA_W-1:0] d, input logic [NUM_BYTES-1:0] p,
                                     input logic odd);
        logic bad = 1'b0;
        for (int b = 0; b < NUM_BYTES; b++)
            if (((ones_in_byte(d, b) + int'(p[b])) % 2) != int'(odd)) bad = 1'b1;
        return bad;
    endfunction

    // Driver: inputs already set just after a rising edge; push expectation, advance.
    task automatic go(input string tag);
        exp_t e;
        logic [DATA_W-1:0]    sd;
        logic [NUM_BYTES-1:0] sp;
        if (tag != "") begin
            e.tag = tag;
            sd = ab_le ? a_data_in : m_ab_d;
            sp = ab_le ? a_par_in  : m_ab_p;
            e.bd   = ab_oe ? sd : '0;
            e.bp   = ab_oe ? (gen_mode ? ref_par(sd, odd_sel) : sp) : '0;
            e.bdrv = ab_oe;
            e.abe  = !(ab_oe && !gen_mode && ref_bad(sd, sp, odd_sel));
            sd = ba_le ? b_data_in : m_ba_d;
            sp = ba_le ? b_par_in  : m_ba_p;
            e.ad   = ba_oe ? sd : '0;
            e.ap   = ba_oe ? sp : '0;
            e.adrv = ba_oe;
            e.bae  = !(ba_oe && ref_bad(sd, sp, odd_sel));
            exp_q.push_back(e);
        end
        if (rst) begin
            m_ab_d = '0; m_ab_p = '0; m_ba_d = '0; m_ba_p = '0;
        end else begin
            if (ab_cap) begin m_ab_d = a_data_in; m_ab_p = a_par_in; end
            if (ba_cap) begin m_ba_d = b_data_in; m_ba_p = b_par_in; end
        end
        @(posedge clk);
        #1;
    endtask

    // Monitor: compares all ports mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (b_data_out !== e.bd || b_par_out !== e.bp || b_drive !== e.bdrv ||
                ab_err_n !== e.abe || a_data_out !== e.ad || a_par_out !== e.ap ||
                a_drive !== e.adrv || ba_err_n !== e.bae) begin
                failures++;
                $display("FAIL %s: got B %h/%b drv%b err%b A %h/%b drv%b err%b exp B %h/%b drv%b err%b A %h/%b drv%b err%b",
                         e.tag, b_data_out, b_par_out, b_drive, ab_err_n,
                         a_data_out, a_par_out, a_drive, ba_err_n,
                         e.bd, e.bp, e.bdrv, e.abe, e.ad, e.ap, e.adrv, e.bae);
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; odd_sel = 1'b0; gen_mode = 1'b1;
        a_data_in = '0; a_par_in = '0; b_data_in = '0; b_par_in = '0;
        ab_le = 1'b0; ab_cap = 1'b0; ab_oe = 1'b1;
        ba_le = 1'b0; ba_cap = 1'b0; ba_oe = 1'b1;
        @(posedge clk); #1;
        go(""); go("");
        rst = 1'b0;
        a_data_in = 16'hFFFF; a_par_in = 2'b11; b_data_in = 16'h5A5A; b_par_in = 2'b01;
        go("R1 reset clears stages");

        // R2 transparent both directions
        ab_le = 1'b1; ba_le = 1'b1;
        a_data_in = 16'hA55A; b_data_in = 16'h1234; b_par_in = ref_par(16'h1234, 1'b0);
        go("R2 transparent");
        a_data_in = 16'h0F01; b_data_in = 16'h8001; b_par_in = ref_par(16'h8001, 1'b0);
        go("R2 transparent");

        // R3 capture, R4 hold
        ab_le = 1'b0; ba_le = 1'b0; ab_cap = 1'b1; ba_cap = 1'b1;
        a_data_in = 16'hC3F0; b_data_in = 16'h7E81; b_par_in = ref_par(16'h7E81, 1'b0);
        go("R3 before edge");
        ab_cap = 1'b0; ba_cap = 1'b0;
        a_data_in = 16'h1111; b_data_in = 16'h2222; b_par_in = 2'b10;
        go("R3 after edge");
        a_data_in = 16'h3333; b_data_in = 16'h4444;
        go("R4 hold");
        go("R4 hold");

        // R5 generate, both senses (R8)
        ab_le = 1'b1; gen_mode = 1'b1; odd_sel = 1'b1;
        a_data_in = 16'h0701; a_par_in = 2'b11;
        go("R5 generate odd");
        odd_sel = 1'b0;
        go("R8 generate even");
        a_data_in = 16'hFF00;
        go("R5 generate even");

        // R6 check mode, error placements
        gen_mode = 1'b0; odd_sel = 1'b0;
        a_data_in = 16'h0301; a_par_in = ref_par(16'h0301, 1'b0);
        go("R6 check clean");
        a_par_in = ref_par(16'h0301, 1'b0) ^ 2'b01;
        go("R6 byte0 error");
        a_par_in = ref_par(16'h0301, 1'b0) ^ 2'b10;
        go("R6 byte1 error");
        a_par_in = ref_par(16'h0301, 1'b0) ^ 2'b11;
        go("R6 both bytes error");
        odd_sel = 1'b1;
        go("R8 odd sense flips result");
        a_par_in = ref_par(16'h0301, 1'b1);
        go("R8 odd clean");

        // R7 B-to-A checks even in generate mode
        gen_mode = 1'b1; ba_le = 1'b1; odd_sel = 1'b0;
        b_data_in = 16'h00FF; b_par_in = ref_par(16'h00FF, 1'b0) ^ 2'b10;
        go("R7 byte1 error under generate");
        b_par_in = ref_par(16'h00FF, 1'b0) ^ 2'b01;
        go("R7 byte0 error");
        b_par_in = ref_par(16'h00FF, 1'b0);
        go("R7 clean");

        // R9 enables off with errors present
        gen_mode = 1'b0;
        a_par_in = ~ref_par(a_data_in, odd_sel); b_par_in = ~ref_par(b_data_in, odd_sel);
        ab_oe = 1'b0;
        go("R9 A-to-B masked");
        ab_oe = 1'b1; ba_oe = 1'b0;
        go("R9 B-to-A masked");
        ba_oe = 1'b1;
        go("R9 flags return");

        // Random traffic covering R2 R3 R4 R6 R7
        for (int n = 0; n < 80; n++) begin
            a_data_in = DATA_W'($urandom); b_data_in = DATA_W'($urandom);
            a_par_in  = NUM_BYTES'($urandom); b_par_in = NUM_BYTES'($urandom);
            ab_le = 1'($urandom); ab_cap = 1'($urandom); ab_oe = ($urandom % 4) != 0;
            ba_le = 1'($urandom); ba_cap = 1'($urandom); ba_oe = ($urandom % 4) != 0;
            gen_mode = 1'($urandom); odd_sel = 1'($urandom);
            go("R6 R7 random");
        end

        @(posedge clk); @(posedge clk);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule